// File: doc/BRIEF.md
# Shift-and-store register with cascade outputs

The block converts a slow serial stream into a parallel word. Bits are clocked into an eight-stage shift register by an external shift clock. A storage stage sits behind the shift register and drives eight parallel outputs that can be switched to high impedance. Two serial outputs carry the last stage onward so several blocks can be chained. One serial output updates on the rising shift-clock edge. The other is a copy that updates on the following falling edge, which gives the next block in the chain a full half period of hold margin.

All logic runs in a fast system-clock domain. The shift-clock, strobe and data pins are treated as slow asynchronous levels. Each one passes through a two-flop synchronizer, and shift-clock edges are found by comparing successive synchronized samples. The data pin gets one extra flop, so the bit taken at an edge is the one that was present before the edge. The strobe is a level: while it is high, the storage stage follows the shift register. Output enable gates only the parallel drivers and is applied combinationally.

None of the pins carries a stream with flow control. They are plain level inputs, so there is no valid/ready handshake and no back-pressure. Each shift-clock edge must stay stable for at least three system cycles to be seen.

Top module: `shift_store_reg`

## Requirements
- R1: On each rising shift-clock edge, stage 0 takes the data pin's value from before the edge, and every stage n takes the old value of stage n-1. Bit i of the parallel output is storage bit i, and storage bit i mirrors stage i, so stage 0 holds the newest bit.
- R2: `ser_fast` always equals the last stage (stage 7). Just after a rising edge it shows the value that stage 6 held before that edge.
- R3: `ser_slow` changes only on a falling shift-clock edge. It then takes the value stage 7 held before that edge, and it holds that value until the next falling edge.
- R4: While the strobe is high, the storage stage equals the shift register and follows it on every rising edge. While the strobe is low, the storage stage holds its value.
- R5: When the synchronized strobe is high in the same system cycle as a detected rising edge, storage captures the register value after the shift.
- R6: With output enable high, `par_en_n` is all zeros and `par_q` drives the storage contents. With output enable low, `par_en_n` is all ones and all eight `par_q` bits are high impedance.
- R7: Toggling output enable changes neither the shift register nor the storage stage, and both serial outputs stay driven and correct while the parallel outputs are disabled.
- R8: A synchronous active-high reset clears every shift stage, the storage stage and `ser_slow` to zero.
- R9: A shift-clock pin edge reaches the registers at the third system-clock rising edge after the pin changes. Before that edge the outputs still show the old state.
- R10: When `ser_slow` of one block feeds the data pin of a second block, the pair behaves as a 16-stage register. After 16 shifts and a strobe, the first bit shifted in sits in stage 7 of the second block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_pin | input | 1 | Asynchronous shift clock |
| strb_pin | input | 1 | Asynchronous strobe, high makes storage follow the register |
| din_pin | input | 1 | Asynchronous serial data |
| oe_pin | input | 1 | Output enable for the parallel outputs, high drives |
| par_q | output | 8 | Tri-state parallel outputs |
| par_en_n | output | 8 | Per-bit active-low driver enable behind `par_q` |
| ser_fast | output | 1 | Cascade output updated on the rising shift edge |
| ser_slow | output | 1 | Cascade output updated on the falling shift edge |

## Verification
Changes on the shift-clock, strobe and data pins take effect at the third system edge after the pin moves. Output enable acts within the same cycle. Every pin is driven on a falling system edge, and the bench waits five cycles before sampling, again on a falling edge, so it always reads settled state. The latency requirement is the exception: it is sampled after exactly two and exactly three edges to catch a result that arrives one cycle early or late. The same-cycle strobe case uses a strobe pulse one system cycle wide, aligned with the shift edge, so that only a capture of the post-shift value gives the expected word.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  localparam int unsigned SSR_STAGES     = 8;
  localparam int unsigned SSR_SYNC_DEPTH = 2;

  typedef struct packed {
    logic sclk;
    logic strb;
    logic din;
  } ssr_pins_t;

  localparam int unsigned SSR_PIN_W = $bits(ssr_pins_t);
endpackage

// File: rtl/ssr_sync.sv
module ssr_sync #(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [DEPTH-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= async_i;
      for (int i = 1; i < DEPTH; i++) begin
        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign sync_o = chain_q[DEPTH-1];
endmodule

// File: rtl/ssr_edge.sv
module ssr_edge
  import ssr_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  ssr_pins_t pins_s,
  output logic      rise_o,
  output logic      fall_o,
  output logic      bit_o,
  output logic      strobe_o
);
  logic sclk_prev_q;
  logic din_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev_q <= 1'b0;
      din_prev_q  <= 1'b0;
    end else begin
      sclk_prev_q <= pins_s.sclk;
      din_prev_q  <= pins_s.din;
    end
  end

  assign rise_o   = pins_s.sclk & ~sclk_prev_q;
  assign fall_o   = ~pins_s.sclk & sclk_prev_q;
  assign bit_o    = din_prev_q;
  assign strobe_o = pins_s.strb;

  // R9
  rise_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/ssr_core.sv
module ssr_core #(
  parameter int unsigned STAGES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_rise,
  input  logic              shift_fall,
  input  logic              ser_bit,
  input  logic              strobe,
  output logic [STAGES-1:0] store_o,
  output logic              ser_fast_o,
  output logic              ser_slow_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_next;
  logic [STAGES-1:0] store_q;
  logic              slow_q;

  always_comb begin
    sr_next = sr_q;
    if (shift_rise) begin
      sr_next = {sr_q[LAST-1:0], ser_bit};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q    <= '0;
      store_q <= '0;
      slow_q  <= 1'b0;
    end else begin
      sr_q <= sr_next;
      if (strobe) begin
        store_q <= sr_next;
      end
      if (shift_fall) begin
        slow_q <= sr_q[LAST];
      end
    end
  end

  assign store_o    = store_q;
  assign ser_fast_o = sr_q[LAST];
  assign ser_slow_o = slow_q;

  // R2
  fast_from_prev_stage_chk: assert property (@(posedge clk) disable iff (rst)
    shift_rise |=> ser_fast_o == $past(sr_q[LAST-1]));
  // R3
  slow_matches_fast_chk: assert property (@(posedge clk) disable iff (rst)
    shift_fall |=> ser_slow_o == ser_fast_o);
  // R4
  store_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe && !shift_rise) |=> store_q == sr_q);
  // R4
  store_holds_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(store_q));
  // R5
  store_post_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe && shift_rise) |=> store_q == sr_q);
  // R8
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (sr_q == '0 && store_q == '0 && !slow_q));
endmodule

// File: rtl/ssr_outdrv.sv
module ssr_outdrv #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             oe,
  input  logic [WIDTH-1:0] store_i,
  output logic [WIDTH-1:0] drv_d,
  output logic [WIDTH-1:0] drv_en_n
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    assign drv_en_n[g] = ~oe;
    assign drv_d[g]    = store_i[g];
  end

  always_comb begin
    if (!$isunknown(oe)) begin
      // R6
      en_all_or_none_chk: assert ($countones(drv_en_n) == 0 ||
                                  $countones(drv_en_n) == WIDTH);
    end
  end
endmodule

// File: rtl/shift_store_reg.sv
module shift_store_reg
  import ssr_pkg::*;
#(
  parameter int unsigned STAGES     = SSR_STAGES,
  parameter int unsigned SYNC_DEPTH = SSR_SYNC_DEPTH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_pin,
  input  logic              strb_pin,
  input  logic              din_pin,
  input  logic              oe_pin,
  output wire  [STAGES-1:0] par_q,
  output logic [STAGES-1:0] par_en_n,
  output logic              ser_fast,
  output logic              ser_slow
);
  ssr_pins_t         pins_raw;
  ssr_pins_t         pins_s;
  logic              rise;
  logic              fall;
  logic              ser_bit;
  logic              strobe;
  logic [STAGES-1:0] store;
  logic [STAGES-1:0] par_d;

  assign pins_raw.sclk = sclk_pin;
  assign pins_raw.strb = strb_pin;
  assign pins_raw.din  = din_pin;

  ssr_sync #(.WIDTH(SSR_PIN_W), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (pins_raw),
    .sync_o  (pins_s)
  );

  ssr_edge u_edge (
    .clk      (clk),
    .rst      (rst),
    .pins_s   (pins_s),
    .rise_o   (rise),
    .fall_o   (fall),
    .bit_o    (ser_bit),
    .strobe_o (strobe)
  );

  ssr_core #(.STAGES(STAGES)) u_core (
    .clk        (clk),
    .rst        (rst),
    .shift_rise (rise),
    .shift_fall (fall),
    .ser_bit    (ser_bit),
    .strobe     (strobe),
    .store_o    (store),
    .ser_fast_o (ser_fast),
    .ser_slow_o (ser_slow)
  );

  ssr_outdrv #(.WIDTH(STAGES)) u_outdrv (
    .oe       (oe_pin),
    .store_i  (store),
    .drv_d    (par_d),
    .drv_en_n (par_en_n)
  );

  for (genvar g = 0; g < STAGES; g++) begin : g_pad
    assign par_q[g] = par_en_n[g] ? 1'bz : par_d[g];
  end
endmodule

// File: tb/shift_store_reg_bench.sv
module shift_store_reg_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, strb = 1'b0, din = 1'b0, oe = 1'b1;
  wire  [7:0] par_q, t_par_q;
  logic [7:0] par_en_n, t_en_n;
  logic ser_fast, ser_slow, t_fast, t_slow;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [7:0] m_sr = '0, m_st = '0, t_sr = '0, t_st = '0;
  logic m_qs2 = 1'b0, t_qs2 = 1'b0;

  always #4 clk = ~clk;

  shift_store_reg u_shift_store_reg (
    .clk(clk), .rst(rst), .sclk_pin(sclk), .strb_pin(strb), .din_pin(din),
    .oe_pin(oe), .par_q(par_q), .par_en_n(par_en_n),
    .ser_fast(ser_fast), .ser_slow(ser_slow)
  );

  shift_store_reg u_tail (
    .clk(clk), .rst(rst), .sclk_pin(sclk), .strb_pin(strb), .din_pin(ser_slow),
    .oe_pin(1'b1), .par_q(t_par_q), .par_en_n(t_en_n),
    .ser_fast(t_fast), .ser_slow(t_slow)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_rise(input bit d);
    t_sr = {t_sr[6:0], m_sr[7]};
    m_sr = {m_sr[6:0], d};
    if (strb) begin
      m_st = m_sr;
      t_st = t_sr;
    end
  endtask

  task automatic model_fall();
    m_qs2 = m_sr[7];
    t_qs2 = t_sr[7];
  endtask

  task automatic check_state(input string req);
    check(par_en_n == (oe ? 8'h00 : 8'hFF), "R6 enable vector", par_en_n,
          oe ? 8'h00 : 8'hFF);
    if (oe) check(par_q == m_st, req, par_q, m_st);
    check(ser_fast == m_sr[7], "R2 ser_fast", ser_fast, m_sr[7]);
    check(ser_slow == m_qs2, "R3 ser_slow", ser_slow, m_qs2);
    check(t_par_q == t_st, "R10 tail storage", t_par_q, t_st);
    check(t_fast == t_sr[7], "R10 tail ser_fast", t_fast, t_sr[7]);
    check(t_slow == t_qs2, "R10 tail ser_slow", t_slow, t_qs2);
  endtask

  task automatic pulse(input bit d);
    din = d;
    idle(5);
    sclk = 1'b1;
    model_rise(d);
    idle(5);
    check_state("R1 storage after rise");
    sclk = 1'b0;
    model_fall();
    idle(5);
    check_state("R3 storage after fall");
  endtask

  task automatic set_strb(input bit v);
    strb = v;
    if (v) begin
      m_st = m_sr;
      t_st = t_sr;
    end
    idle(5);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    sclk = 1'b0;
    idle(3);
    rst = 1'b0;
    m_sr = '0; m_st = '0; t_sr = '0; t_st = '0; m_qs2 = 1'b0; t_qs2 = 1'b0;
    idle(2);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] exp16;
    int r;
    r = $urandom(32'd4094);
    strb = 1'b0; oe = 1'b1;
    idle(1);
    do_reset();
    // R8 reset state
    check(par_q == 8'h00, "R8 par_q after reset", par_q, 8'h00);
    check(ser_fast == 1'b0, "R8 ser_fast after reset", ser_fast, 1'b0);
    check(ser_slow == 1'b0, "R8 ser_slow after reset", ser_slow, 1'b0);

    // R1 directed: single one walks from stage 0 to stage 7
    set_strb(1'b1);
    pulse(1'b1);
    check(par_q == 8'h01, "R1 first bit in stage 0", par_q, 8'h01);
    for (int i = 0; i < 7; i++) pulse(1'b0);
    check(par_q == 8'h80, "R1 bit reached stage 7", par_q, 8'h80);
    check(ser_fast == 1'b1, "R2 last stage on ser_fast", ser_fast, 1'b1);

    // R4 hold with strobe low, then transparent when raised
    set_strb(1'b0);
    pulse(1'b1); pulse(1'b1); pulse(1'b0);
    check(par_q == 8'h80, "R4 storage holds", par_q, 8'h80);
    set_strb(1'b1);
    check(par_q == 8'h06, "R4 storage follows", par_q, 8'h06);

    // R5 one-cycle strobe coincident with the rising edge
    set_strb(1'b0);
    din = 1'b1;
    idle(5);
    sclk = 1'b1;
    strb = 1'b1;
    @(negedge clk);
    strb = 1'b0;
    t_sr = {t_sr[6:0], m_sr[7]};
    m_sr = {m_sr[6:0], 1'b1};
    m_st = m_sr;
    t_st = t_sr;
    idle(5);
    check(par_q == 8'h0D, "R5 post-shift capture", par_q, 8'h0D);
    sclk = 1'b0;
    model_fall();
    idle(5);
    check_state("R5 state after fall");

    // R9 latency: stage 6 differs from stage 7
    pulse(1'b1); pulse(1'b1); pulse(1'b1);
    din = 1'b0;
    idle(5);
    sclk = 1'b1;
    idle(2);
    check(ser_fast == 1'b0, "R9 not yet after two edges", ser_fast, 1'b0);
    idle(1);
    check(ser_fast == 1'b1, "R9 due at third edge", ser_fast, 1'b1);
    model_rise(1'b0);
    idle(3);
    sclk = 1'b0;
    model_fall();
    idle(5);
    check_state("R9 state after fall");

    // R7 output enable does not touch state
    oe = 1'b0;
    idle(1);
    check(par_en_n == 8'hFF, "R6 all bits high impedance", par_en_n, 8'hFF);
    set_strb(1'b1);
    pulse(1'b1); pulse(1'b0); pulse(1'b1);
    for (int i = 0; i < 10; i++) begin
      oe = ~oe;
      @(negedge clk);
    end
    oe = 1'b1;
    idle(2);
    check_state("R7 storage intact after enable toggles");

    // Random mix
    for (int i = 0; i < 150; i++) begin
      r = $urandom;
      if (r[3:2] == 2'b00) set_strb(r[4]);
      if (r[6:5] == 2'b00) begin
        oe = r[7];
        idle(1);
      end
      pulse(r[0]);
    end

    // R10 cascade of two blocks
    oe = 1'b1;
    set_strb(1'b0);
    exp16 = '0;
    for (int i = 0; i < 16; i++) begin
      r = $urandom;
      exp16 = {exp16[14:0], r[0]};
      pulse(r[0]);
    end
    set_strb(1'b1);
    check({t_par_q, par_q} == exp16, "R10 16-bit chain", {t_par_q, par_q}, exp16);

    // R8 reset mid-run
    do_reset();
    check({t_par_q, par_q} == 16'h0000, "R8 storage cleared", {t_par_q, par_q}, 16'h0000);
    check({ser_fast, ser_slow, t_fast, t_slow} == 4'h0, "R8 serial cleared",
          {ser_fast, ser_slow, t_fast, t_slow}, 4'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule